// File: doc/BRIEF.md
# Effective Address Generation Unit

This block works out where an instruction's operand lives. Decode hands it a request holding a mode code, a register number, an operand size, up to two 16-bit extension words, the contents of the base address register, the current program counter and the contents of the chosen index register. One clock later the block returns a 32-bit memory address. For the auto-modify modes it also returns the updated base register value, to be written back to the register file. Modes whose operand sits in a register or in the instruction stream return no address. They raise a non-memory flag.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream, with one result register between them. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being emptied in the same cycle. A result is consumed on an edge where `res_valid` and `res_ready` are both high. While `res_valid` is high and `res_ready` is low, every result field stays frozen and no new request is taken. With `res_ready` held high, the block accepts one request per cycle.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode code 2 (indirect) returns the base register contents unchanged as the address, with no write-back.
- R2: Mode code 3 (post-increment) returns the base value as the address. It also asserts write-back with the new value base + N.
- R3: Mode code 4 (pre-decrement) asserts write-back with base − N and returns that reduced value as the address.
- R4: N is taken from the size code: 0 = byte gives 1, 1 = word gives 2, 2 or 3 = long gives 4. For register number 7 (the stack pointer), a byte access gives N = 2.
- R5: Mode code 5 returns base + the 16-bit displacement in `req_ext0`, sign-extended. All address sums wrap modulo 2^32.
- R6: Mode code 6 returns base + index + the sign-extended 8-bit displacement in `req_ext0[7:0]`. When `req_idx_long` is 1 the index is all 32 bits of `req_idx_val`. When it is 0 the index is `req_idx_val[15:0]`, sign-extended.
- R7: Program-counter-relative forms replace the base with `req_pc`. Mode code 9 uses the 16-bit displacement as in R5, and mode code 10 uses the index and 8-bit displacement as in R6.
- R8: Mode code 7 returns `req_ext0` sign-extended. Mode code 8 returns `{req_ext0, req_ext1}`, with the first word as the upper half.
- R9: Mode codes 0, 1, 11 and the unused codes 12 to 15 set `res_nonmem`, return address 0 and do not write back. Every memory mode clears `res_nonmem`.
- R10: `res_wb_en` is set only for mode codes 3 and 4. When it is set, `res_wb_reg` equals the request's register number.
- R11: A result appears with `res_valid` on the cycle after its request is accepted. Results leave in request order. While the output is stalled, every result field holds.
- R12: After reset `res_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mode | input | 4 | Addressing mode code |
| req_reg | input | 3 | Base register number |
| req_size | input | 2 | Operand size code |
| req_ext0 | input | 16 | First extension word |
| req_ext1 | input | 16 | Second extension word |
| req_base | input | 32 | Base address register contents |
| req_pc | input | 32 | Address of the first extension word |
| req_idx_val | input | 32 | Index register contents |
| req_idx_long | input | 1 | 1 = full index, 0 = sign-extended low half |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 32 | Effective address |
| res_nonmem | output | 1 | Operand is not in memory |
| res_wb_en | output | 1 | Write back the base register |
| res_wb_reg | output | 3 | Register to write back |
| res_wb_val | output | 32 | New base register value |

## Verification
The checker assumes that request fields matter only on the edge where a request is accepted, and that `res_ready` is a known value at every edge. The stall and latency properties depend on nothing else. The stimulus holds each request steady until it sees `req_ready`, and drives all inputs just after a clock edge. It also switches `res_ready` through a pseudo-random pattern, so stalls land both on freshly loaded results and on results that have already waited. Operands cover wraparound at both ends of the address space, negative displacements and negative short indices.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    EA_DREG    = 4'd0,
    EA_AREG    = 4'd1,
    EA_IND     = 4'd2,
    EA_POSTINC = 4'd3,
    EA_PREDEC  = 4'd4,
    EA_BDISP   = 4'd5,
    EA_BINDEX  = 4'd6,
    EA_ABS16   = 4'd7,
    EA_ABS32   = 4'd8,
    EA_PDISP   = 4'd9,
    EA_PINDEX  = 4'd10,
    EA_IMM     = 4'd11
  } ea_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } ea_size_e;

endpackage

// File: rtl/ea_step_sel.sv
module ea_step_sel #(
  parameter int AW        = 32,
  parameter int RW        = 3,
  parameter int SP_NUM    = 7,
  parameter bit SP_ALIGN  = 1'b1
) (
  input  logic [1:0]    size,
  input  logic [RW-1:0] regnum,
  output logic [AW-1:0] step
);
  import ea_pkg::*;

  logic       is_sp;
  logic [2:0] raw_step;
  logic [2:0] adj_step;

  assign is_sp = (regnum == RW'(SP_NUM));

  always_comb begin
    case (ea_size_e'(size))
      SZ_BYTE: raw_step = 3'd1;
      SZ_WORD: raw_step = 3'd2;
      default: raw_step = 3'd4;
    endcase
  end

  // Byte moves through the stack pointer keep it on an even address.
  generate
    if (SP_ALIGN) begin : g_sp_align
      assign adj_step = (is_sp && raw_step == 3'd1) ? 3'd2 : raw_step;
    end else begin : g_no_align
      logic unused_sp;
      assign unused_sp = is_sp;
      assign adj_step  = raw_step;
    end
  endgenerate

  assign step = AW'(adj_step);
endmodule

// File: rtl/ea_index_fmt.sv
module ea_index_fmt #(
  parameter int AW  = 32,
  parameter int HW  = 16
) (
  input  logic [AW-1:0] idx_val,
  input  logic          idx_long,
  input  logic [7:0]    disp8,
  output logic [AW-1:0] idx_term
);
  logic [AW-1:0] idx_ext;
  logic [AW-1:0] d8_ext;

  assign idx_ext  = idx_long ? idx_val
                             : {{(AW-HW){idx_val[HW-1]}}, idx_val[HW-1:0]};
  assign d8_ext   = {{(AW-8){disp8[7]}}, disp8};
  assign idx_term = idx_ext + d8_ext;
endmodule

// File: rtl/ea_addr_core.sv
module ea_addr_core #(
  parameter int AW     = 32,
  parameter int RW     = 3,
  parameter int XW     = 16,
  parameter int SP_NUM = 7
) (
  input  logic [3:0]    mode,
  input  logic [RW-1:0] regnum,
  input  logic [1:0]    size,
  input  logic [XW-1:0] ext0,
  input  logic [XW-1:0] ext1,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] idx_val,
  input  logic          idx_long,
  output logic [AW-1:0] addr,
  output logic          nonmem,
  output logic          wb_en,
  output logic [AW-1:0] wb_val
);
  import ea_pkg::*;

  localparam int SXW = AW - XW;

  logic [AW-1:0] step;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] d16_ext;
  logic [AW-1:0] inc_val;
  logic [AW-1:0] dec_val;
  logic [AW-1:0] sel_base;
  logic          use_pc;

  ea_step_sel #(.AW(AW), .RW(RW), .SP_NUM(SP_NUM), .SP_ALIGN(1'b1)) u_step (
    .size   (size),
    .regnum (regnum),
    .step   (step)
  );

  ea_index_fmt #(.AW(AW), .HW(16)) u_idx (
    .idx_val  (idx_val),
    .idx_long (idx_long),
    .disp8    (ext0[7:0]),
    .idx_term (idx_term)
  );

  assign d16_ext  = {{SXW{ext0[XW-1]}}, ext0};
  assign inc_val  = base + step;
  assign dec_val  = base - step;
  assign use_pc   = (mode == EA_PDISP) || (mode == EA_PINDEX);
  assign sel_base = use_pc ? pc : base;

  always_comb begin
    addr   = '0;
    nonmem = 1'b0;
    wb_en  = 1'b0;
    wb_val = '0;
    case (mode)
      EA_IND:     addr = base;
      EA_POSTINC: begin
        addr   = base;
        wb_en  = 1'b1;
        wb_val = inc_val;
      end
      EA_PREDEC:  begin
        addr   = dec_val;
        wb_en  = 1'b1;
        wb_val = dec_val;
      end
      EA_BDISP,
      EA_PDISP:   addr = sel_base + d16_ext;
      EA_BINDEX,
      EA_PINDEX:  addr = sel_base + idx_term;
      EA_ABS16:   addr = d16_ext;
      EA_ABS32:   addr = {ext0, ext1};
      default:    nonmem = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit #(
  parameter int AW     = 32,
  parameter int RW     = 3,
  parameter int XW     = 16,
  parameter int SP_NUM = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_mode,
  input  logic [RW-1:0] req_reg,
  input  logic [1:0]    req_size,
  input  logic [XW-1:0] req_ext0,
  input  logic [XW-1:0] req_ext1,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_pc,
  input  logic [AW-1:0] req_idx_val,
  input  logic          req_idx_long,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_addr,
  output logic          res_nonmem,
  output logic          res_wb_en,
  output logic [RW-1:0] res_wb_reg,
  output logic [AW-1:0] res_wb_val
);
  logic [AW-1:0] c_addr;
  logic          c_nonmem;
  logic          c_wb_en;
  logic [AW-1:0] c_wb_val;
  logic          take;

  ea_addr_core #(.AW(AW), .RW(RW), .XW(XW), .SP_NUM(SP_NUM)) u_core (
    .mode     (req_mode),
    .regnum   (req_reg),
    .size     (req_size),
    .ext0     (req_ext0),
    .ext1     (req_ext1),
    .base     (req_base),
    .pc       (req_pc),
    .idx_val  (req_idx_val),
    .idx_long (req_idx_long),
    .addr     (c_addr),
    .nonmem   (c_nonmem),
    .wb_en    (c_wb_en),
    .wb_val   (c_wb_val)
  );

  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_addr   <= '0;
      res_nonmem <= 1'b0;
      res_wb_en  <= 1'b0;
      res_wb_reg <= '0;
      res_wb_val <= '0;
    end else if (take) begin
      res_valid  <= 1'b1;
      res_addr   <= c_addr;
      res_nonmem <= c_nonmem;
      res_wb_en  <= c_wb_en;
      res_wb_reg <= req_reg;
      res_wb_val <= c_wb_val;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/ea_gen_unit_chk.sv
module ea_gen_unit_chk #(
  parameter int AW = 32,
  parameter int RW = 3,
  parameter int XW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [3:0]    req_mode,
  input logic [RW-1:0] req_reg,
  input logic [AW-1:0] req_base,
  input logic          res_valid,
  input logic          res_ready,
  input logic [AW-1:0] res_addr,
  input logic          res_nonmem,
  input logic          res_wb_en,
  input logic [RW-1:0] res_wb_reg,
  input logic [AW-1:0] res_wb_val
);
  import ea_pkg::*;

  logic acc;
  assign acc = req_valid && req_ready;

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);  // R11

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) &&
      $stable(res_nonmem) && $stable(res_wb_en) && $stable(res_wb_val) &&
      $stable(res_wb_reg)));  // R11

  AST_IND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_mode == EA_IND) |=> (res_addr == $past(req_base)));  // R1

  AST_POSTINC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_mode == EA_POSTINC) |=> (res_addr == $past(req_base) && res_wb_en));  // R2

  AST_PREDEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_mode == EA_PREDEC) |=> (res_addr == res_wb_val && res_wb_en));  // R3

  AST_WB_ONLY_AUTOMOD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_mode != EA_POSTINC && req_mode != EA_PREDEC) |=> !res_wb_en);  // R10

  AST_WB_REG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_mode == EA_POSTINC || req_mode == EA_PREDEC)) |=>
      (res_wb_reg == $past(req_reg)));  // R10

  AST_NONMEM_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_nonmem) |-> (!res_wb_en && res_addr == '0));  // R9
endmodule

bind ea_gen_unit ea_gen_unit_chk #(.AW(AW), .RW(RW), .XW(XW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_mode   (req_mode),
  .req_reg    (req_reg),
  .req_base   (req_base),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_addr   (res_addr),
  .res_nonmem (res_nonmem),
  .res_wb_en  (res_wb_en),
  .res_wb_reg (res_wb_reg),
  .res_wb_val (res_wb_val)
);

// File: tb/ea_gen_unit_tb.sv
module ea_gen_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [2:0]  req_reg = '0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_ext0 = '0;
  logic [15:0] req_ext1 = '0;
  logic [31:0] req_base = '0;
  logic [31:0] req_pc = '0;
  logic [31:0] req_idx_val = '0;
  logic        req_idx_long = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_addr;
  logic        res_nonmem;
  logic        res_wb_en;
  logic [2:0]  res_wb_reg;
  logic [31:0] res_wb_val;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct {
    logic [31:0] addr;
    logic        nonmem;
    logic        wb_en;
    logic [2:0]  wb_reg;
    logic [31:0] wb_val;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  ea_gen_unit u_dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic exp_t model(input logic [3:0] m, input logic [2:0] r,
      input logic [1:0] sz, input logic [15:0] e0, input logic [15:0] e1,
      input logic [31:0] b, input logic [31:0] pc, input logic [31:0] ix,
      input logic il);
    exp_t e;
    logic [31:0] n, xi, d8;
    n  = (sz == 2'd0) ? ((r == 3'd7) ? 32'd2 : 32'd1) : (sz == 2'd1) ? 32'd2 : 32'd4;
    xi = il ? ix : sx16(ix[15:0]);
    d8 = {{24{e0[7]}}, e0[7:0]};
    e.addr = 0; e.nonmem = 0; e.wb_en = 0; e.wb_reg = r; e.wb_val = 0;
    case (m)
      4'd2:  begin e.addr = b; e.tag = "R1"; end
      4'd3:  begin e.addr = b; e.wb_en = 1; e.wb_val = b + n; e.tag = "R2"; end
      4'd4:  begin e.wb_val = b - n; e.addr = b - n; e.wb_en = 1; e.tag = "R3"; end
      4'd5:  begin e.addr = b + sx16(e0); e.tag = "R5"; end
      4'd6:  begin e.addr = b + xi + d8; e.tag = "R6"; end
      4'd7:  begin e.addr = sx16(e0); e.tag = "R8"; end
      4'd8:  begin e.addr = {e0, e1}; e.tag = "R8"; end
      4'd9:  begin e.addr = pc + sx16(e0); e.tag = "R7"; end
      4'd10: begin e.addr = pc + xi + d8; e.tag = "R7"; end
      default: begin e.nonmem = 1; e.tag = "R9"; end
    endcase
    return e;
  endfunction

  task automatic send(input logic [3:0] m, input logic [2:0] r, input logic [1:0] sz,
      input logic [15:0] e0, input logic [15:0] e1, input logic [31:0] b,
      input logic [31:0] pc, input logic [31:0] ix, input logic il, input string tag);
    exp_t e;
    e = model(m, r, sz, e0, e1, b, pc, ix, il);
    if (tag != "") e.tag = tag;
    @(posedge clk); #1;
    req_valid = 1; req_mode = m; req_reg = r; req_size = sz; req_ext0 = e0;
    req_ext1 = e1; req_base = b; req_pc = pc; req_idx_val = ix; req_idx_long = il;
    do @(negedge clk); while (!req_ready);
    sb.push_back(e);
    @(negedge clk);
    chk(res_valid === 1'b1, "R11", "valid one cycle after accept", 32'(res_valid), 32'd1);
    req_valid = 0;
  endtask

  // Monitor: compare each consumed result against the queue head.
  logic        prev_stall = 0;
  logic [31:0] prev_addr, prev_wbv;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall)
          chk(res_valid && res_addr == prev_addr && res_wb_val == prev_wbv,
              "R11", "held while stalled", res_addr, prev_addr);
        prev_stall = res_valid && !res_ready;
        prev_addr  = res_addr;
        prev_wbv   = res_wb_val;
        if (res_valid && res_ready) begin
          if (sb.size() == 0) chk(0, "R11", "unexpected result", res_addr, 0);
          else begin
            exp_t e;
            e = sb.pop_front();
            chk(res_nonmem == e.nonmem, e.tag, "nonmem", 32'(res_nonmem), 32'(e.nonmem));
            chk(res_addr == e.addr, e.tag, "addr", res_addr, e.addr);
            chk(res_wb_en == e.wb_en, e.wb_en ? e.tag : "R10", "wb_en", 32'(res_wb_en), 32'(e.wb_en));
            if (e.wb_en) begin
              chk(res_wb_val == e.wb_val, e.tag, "wb_val", res_wb_val, e.wb_val);
              chk(res_wb_reg == e.wb_reg, "R10", "wb_reg", 32'(res_wb_reg), 32'(e.wb_reg));
            end
          end
        end
      end
    end
  end

  // Output back-pressure pattern.
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      res_ready = bp_on ? lfsr[0] : 1'b1;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(res_valid === 1'b0, "R12", "res_valid after reset", 32'(res_valid), 0);
    chk(req_ready === 1'b1, "R12", "req_ready after reset", 32'(req_ready), 1);

    send(4'd2, 3'd1, 2'd1, 0, 0, 32'h0000_1234, 0, 0, 0, "R1");
    send(4'd3, 3'd2, 2'd0, 0, 0, 32'h0000_1000, 0, 0, 0, "R4");
    send(4'd3, 3'd2, 2'd1, 0, 0, 32'h0000_1000, 0, 0, 0, "R2");
    send(4'd3, 3'd2, 2'd2, 0, 0, 32'hFFFF_FFFE, 0, 0, 0, "R2");
    send(4'd3, 3'd7, 2'd0, 0, 0, 32'h0000_2000, 0, 0, 0, "R4");
    send(4'd4, 3'd7, 2'd0, 0, 0, 32'h0000_2000, 0, 0, 0, "R4");
    send(4'd4, 3'd3, 2'd0, 0, 0, 32'h0000_2000, 0, 0, 0, "R3");
    send(4'd4, 3'd3, 2'd3, 0, 0, 32'h0000_0000, 0, 0, 0, "R3");
    send(4'd5, 3'd0, 2'd1, 16'hFFF0, 0, 32'h0000_0008, 0, 0, 0, "R5");
    send(4'd5, 3'd0, 2'd1, 16'h7FFF, 0, 32'h0001_0000, 0, 0, 0, "R5");
    send(4'd6, 3'd4, 2'd1, 16'h0080, 0, 32'h0000_1000, 0, 32'h1234_FFFE, 0, "R6");
    send(4'd6, 3'd4, 2'd1, 16'h007F, 0, 32'h0000_1000, 0, 32'h1234_FFFE, 1, "R6");
    send(4'd7, 3'd0, 2'd1, 16'h8000, 0, 0, 0, 0, 0, "R8");
    send(4'd8, 3'd0, 2'd1, 16'hDEAD, 16'hBEEF, 0, 0, 0, 0, "R8");
    send(4'd9, 3'd0, 2'd1, 16'hFFFC, 0, 32'hCAFE_0000, 32'h0000_0100, 0, 0, "R7");
    send(4'd10, 3'd0, 2'd1, 16'h00F0, 0, 32'hCAFE_0000, 32'h0000_0100, 32'h0000_8000, 0, "R7");
    send(4'd0, 3'd5, 2'd2, 16'h1111, 0, 32'h5555_5555, 0, 0, 0, "R9");
    send(4'd11, 3'd5, 2'd2, 16'h1111, 0, 32'h5555_5555, 0, 0, 0, "R9");
    send(4'd14, 3'd5, 2'd2, 16'h1111, 0, 32'h5555_5555, 0, 0, 0, "R9");

    bp_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rb, rp, rx;
      rb = {lfsr, ~lfsr} ^ 32'(i * 32'h9E37);
      rp = {~lfsr, lfsr} + 32'(i);
      rx = {lfsr[7:0], lfsr, lfsr[15:8]};
      send(4'(lfsr % 13), lfsr[6:4], lfsr[9:8], lfsr ^ 16'h5A5A, ~lfsr,
           rb, rp, rx, lfsr[11], "");
    end
    bp_on = 1'b0;
    repeat (10) @(posedge clk);
    chk(sb.size() == 0, "R11", "all results drained", 32'(sb.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule